// File: doc/BRIEF.md
# UART receive holding FIFO

This block is the receive half of one serial channel. The RX line passes through a two-flop synchronizer into a deserializer. The deserializer runs from a 16x oversampling tick that the block receives as an input. It checks the start bit at mid-bit and samples each data, parity and stop bit at the centre of its bit time. It then turns the frame into a character plus three error flags: parity, framing and break.

Each completed character, together with its flags, goes into a holding queue. The host reads from the queue one entry at a time. The head entry is always shown on the read port, and a one-cycle read strobe removes it. A configuration bit selects between two queue modes. In deep mode the queue holds 64 entries, and anything that arrives while it is full is discarded. In single mode only one slot is used, and each new arrival replaces whatever is in it. A sticky overrun flag records every lost or replaced character, and a status-read strobe clears it.

Word length, parity and stop-bit count are static line settings. Changing the queue mode empties the queue and clears the flags.

Top module: `rxq_channel`

## Requirements
- R1: After reset, data_ready and overrun are 0.
- R2: Frames are one low start bit, then cfg_wlen+5 data bits sent LSB first (code 0=5, 1=6, 2=7, 3=8 bits), then an optional parity bit, then one or two stop bits. Data bits above the word length read as 0.
- R3: With cfg_par_en=1, the parity bit must make the count of ones (data plus parity) even when cfg_par_even=1, or odd when it is 0. A mismatch sets rd_perr for that character only.
- R4: A low first stop bit sets rd_ferr. With cfg_two_stop=1, a low second stop bit also sets rd_ferr. The character is still stored.
- R5: All data bits 0, the parity bit (if enabled) 0 and the first stop bit low together set rd_brk as well as rd_ferr. After such a character the receiver waits for the line to return high before it looks for a new start bit, so a held-low line produces exactly one character.
- R6: A low pulse shorter than 8 oversampling ticks is treated as noise and produces no character.
- R7: In deep mode (cfg_fifo_en=1), characters are read out in arrival order. The head character and its flags appear together while data_ready=1, and rd_stb removes the head. A read strobe while the queue is empty has no effect.
- R8: In deep mode the queue holds 64 characters. A character that completes while 64 are held is discarded and sets overrun. The stored 64 are unchanged.
- R9: In single mode (cfg_fifo_en=0), at most one character is held. A new character replaces an unread one and sets overrun.
- R10: overrun stays set until an st_rd strobe clears it. A new loss in the same cycle as the strobe keeps it set.
- R11: Any change of cfg_fifo_en discards all held characters and clears overrun.
- R12: The receiver advances only on os_tick cycles, so frames are received correctly whatever the spacing of the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | 16x oversampling enable |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_two_stop | input | 1 | Two stop bits expected |
| cfg_fifo_en | input | 1 | 1 = 64-deep queue, 0 = single slot |
| rd_stb | input | 1 | Removes the head character |
| st_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Head character (0 when empty) |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| rd_brk | output | 1 | Head break indication |
| data_ready | output | 1 | At least one unread character |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
A character is pushed at the centre of its last stop bit: eight ticks into that bit, plus two synchronizer cycles and two register stages. So the result is always due well before the stop bit ends. The bench therefore drives each complete frame, idles a few cycles and only then samples data_ready, the head and its flags. A read strobe or a status strobe takes effect at the next edge, and the bench samples one cycle after it. A change of queue mode empties the queue at the next edge, and the check waits two cycles.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rxq_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP1,
        S_STOP2,
        S_WAITH
    } rxq_state_e;

endpackage

// File: rtl/rxq_deser.sv
module rxq_deser
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_in,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       two_stop,
    output logic       push_o,
    output rxq_entry_t entry_o
);
    localparam int CW  = $clog2(OSR);
    localparam int VAL = OSR / 2 - 2;

    typedef struct packed {
        rxq_state_e  st;
        logic [CW-1:0] cnt;
        logic [2:0]  idx;
        logic [7:0]  sh;
        logic        pbit;
        logic        s1bad;
        logic        push;
        rxq_entry_t  ent;
        logic [1:0]  sync;
    } deser_t;

    deser_t q, d;

    function automatic rxq_entry_t mk_entry(input logic [7:0] sh, input logic pbit,
                                            input logic s1bad, input logic bad);
        rxq_entry_t e;
        e.data = sh;
        e.perr = par_en & (^sh ^ pbit ^ ~par_even);
        e.ferr = bad;
        e.brk  = (sh == 8'h00) & (~par_en | ~pbit) & s1bad;
        return e;
    endfunction

    logic       rxs;
    logic       at_end;
    logic       bit_due;
    logic [2:0] last_idx;

    always_comb begin
        rxs      = q.sync[1];
        at_end   = (q.cnt == CW'(OSR - 1));
        bit_due  = tick & at_end;
        last_idx = 3'd4 + {1'b0, wlen};
        d        = q;
        d.push   = 1'b0;
        d.sync   = {q.sync[0], rx_in};
        if (tick && (q.st inside {S_DATA, S_PAR, S_STOP1, S_STOP2})) begin
            d.cnt = at_end ? '0 : q.cnt + 1'b1;
        end
        case (q.st)
            S_IDLE: begin
                if (tick && !rxs) begin
                    d.st  = S_START;
                    d.cnt = '0;
                end
            end
            S_START: begin
                if (tick) begin
                    if (rxs) begin
                        d.st = S_IDLE;
                    end else if (q.cnt == CW'(VAL)) begin
                        d.st  = S_DATA;
                        d.cnt = '0;
                        d.idx = '0;
                        d.sh  = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (bit_due) begin
                    d.sh[q.idx] = rxs;
                    if (q.idx == last_idx) begin
                        d.st = par_en ? S_PAR : S_STOP1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            S_PAR: begin
                if (bit_due) begin
                    d.pbit = rxs;
                    d.st   = S_STOP1;
                end
            end
            S_STOP1: begin
                if (bit_due) begin
                    d.s1bad = ~rxs;
                    if (two_stop) begin
                        d.st = S_STOP2;
                    end else begin
                        d.push = 1'b1;
                        d.ent  = mk_entry(q.sh, par_en ? q.pbit : 1'b0, ~rxs, ~rxs);
                        d.st   = rxs ? S_IDLE : S_WAITH;
                    end
                end
            end
            S_STOP2: begin
                if (bit_due) begin
                    d.push = 1'b1;
                    d.ent  = mk_entry(q.sh, par_en ? q.pbit : 1'b0, q.s1bad, q.s1bad | ~rxs);
                    d.st   = rxs ? S_IDLE : S_WAITH;
                end
            end
            S_WAITH: begin
                if (rxs) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign push_o  = q.push;
    assign entry_o = q.ent;

endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int W     = 11,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push,
    input  rxq_entry_t    wr_ent,
    input  logic          pop,
    input  logic          st_clr,
    output rxq_entry_t    head,
    output logic          ready,
    output logic          ovr,
    output logic [LW-1:0] level_o
);
    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [LW-1:0] level;
        logic          ovr;
        logic          en_q;
    } store_t;

    store_t q, d;
    logic   wr_en;
    logic   do_pop;
    logic   set_ovr;
    logic [$bits(rxq_entry_t)-1:0] rd_word;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        d.en_q  = fifo_en;
        wr_en   = 1'b0;
        set_ovr = 1'b0;
        do_pop  = pop && (q.level != '0);
        if (fifo_en != q.en_q) begin
            d.rd_ptr = '0;
            d.wr_ptr = '0;
            d.level  = '0;
            d.ovr    = 1'b0;
        end else if (fifo_en) begin
            if (push) begin
                if (q.level == LW'(DEPTH)) set_ovr = 1'b1;
                else                       wr_en   = 1'b1;
            end
            if (wr_en)  d.wr_ptr = bump(q.wr_ptr);
            if (do_pop) d.rd_ptr = bump(q.rd_ptr);
            d.level = q.level + LW'(wr_en) - LW'(do_pop);
            d.ovr   = set_ovr | (q.ovr & ~st_clr);
        end else begin
            wr_en = push;
            if (push && (q.level != '0) && !do_pop) set_ovr = 1'b1;
            if (push)        d.level = LW'(1);
            else if (do_pop) d.level = '0;
            d.ovr = set_ovr | (q.ovr & ~st_clr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    rxq_mem #(
        .W    ($bits(rxq_entry_t)),
        .DEPTH(DEPTH)
    ) u_mem (
        .clk  (clk),
        .we   (wr_en),
        .waddr(q.wr_ptr),
        .wdata(wr_ent),
        .raddr(q.rd_ptr),
        .rdata(rd_word)
    );

    assign ready   = (q.level != '0);
    assign head    = ready ? rxq_entry_t'(rd_word) : '0;
    assign ovr     = q.ovr;
    assign level_o = q.level;

endmodule

// File: rtl/rxq_channel.sv
module rxq_channel
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OSR   = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_two_stop,
    input  logic       cfg_fifo_en,
    input  logic       rd_stb,
    input  logic       st_rd,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       data_ready,
    output logic       overrun
);
    logic          rx_push;
    rxq_entry_t    rx_ent;
    rxq_entry_t    head_ent;
    logic [LW-1:0] fifo_level;

    rxq_deser #(.OSR(OSR)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .rx_in   (rx_in),
        .wlen    (cfg_wlen),
        .par_en  (cfg_par_en),
        .par_even(cfg_par_even),
        .two_stop(cfg_two_stop),
        .push_o  (rx_push),
        .entry_o (rx_ent)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .fifo_en(cfg_fifo_en),
        .push   (rx_push),
        .wr_ent (rx_ent),
        .pop    (rd_stb),
        .st_clr (st_rd),
        .head   (head_ent),
        .ready  (data_ready),
        .ovr    (overrun),
        .level_o(fifo_level)
    );

    assign rd_data = head_ent.data;
    assign rd_perr = head_ent.perr;
    assign rd_ferr = head_ent.ferr;
    assign rd_brk  = head_ent.brk;

endmodule

// File: rtl/rxq_channel_chk.sv
module rxq_channel_chk #(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_fifo_en,
    input logic          rd_stb,
    input logic          st_rd,
    input logic          data_ready,
    input logic          overrun,
    input logic          push,
    input logic [LW-1:0] level
);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    p_drop_sets_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fifo_en && $past(cfg_fifo_en) && push && (level == LW'(DEPTH)) |=> overrun);

    p_single_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en && !$past(cfg_fifo_en) |-> level <= LW'(1));

    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en != $past(cfg_fifo_en)) |=> !data_ready && !overrun);

    p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd && !push |=> !overrun);

    p_pop_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && (level == LW'(1)) && !push && (cfg_fifo_en == $past(cfg_fifo_en))
        |=> !data_ready);

endmodule

bind rxq_channel rxq_channel_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_fifo_en(cfg_fifo_en),
    .rd_stb     (rd_stb),
    .st_rd      (st_rd),
    .data_ready (data_ready),
    .overrun    (overrun),
    .push       (rx_push),
    .level      (fifo_level)
);

// File: tb/rxq_channel_tb.sv
module rxq_channel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b1;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_fifo_en = 1'b1;
    logic       rd_stb = 1'b0;
    logic       st_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun;

    int checks = 0;
    int errors = 0;
    int tdiv = 1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rxq_channel u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_two_stop(cfg_two_stop), .cfg_fifo_en(cfg_fifo_en),
        .rd_stb(rd_stb), .st_rd(st_rd), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .data_ready(data_ready), .overrun(overrun)
    );

    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (c >= tdiv - 1) begin os_tick = 1'b1; c = 0; end
            else begin os_tick = 1'b0; c = c + 1; end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_in = v;
        repeat (16 * tdiv) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] dv, input int nb, input bit flip_par,
                        input bit s1, input bit s2, input int low_hold);
        logic [7:0] m;
        logic pb;
        m  = dv & 8'((1 << nb) - 1);
        pb = (^m) ^ ~cfg_par_even ^ flip_par;
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) hold_bit(m[i]);
        if (cfg_par_en) hold_bit(pb);
        hold_bit(s1);
        if (cfg_two_stop) hold_bit(s2);
        repeat (low_hold) @(negedge clk);
        rx_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_expect(input string req, input logic [7:0] dv, input bit pe,
                             input bit fe, input bit bk);
        chk(req, "data_ready", data_ready, 1);
        chk(req, "rd_data", rd_data, dv);
        chk(req, "rd_perr", rd_perr, pe);
        chk(req, "rd_ferr", rd_ferr, fe);
        chk(req, "rd_brk", rd_brk, bk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "overrun", overrun, 0);

        // R2/R3: full 8-bit sweep, even parity, one entry at a time
        cfg_par_en = 1'b1;
        cfg_par_even = 1'b1;
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 8, 0, 1, 1, 0);
            rd_expect("R2", 8'(v), 0, 0, 0);
        end

        // R2: shorter word lengths, no parity
        cfg_par_en = 1'b0;
        for (int w = 0; w < 3; w++) begin
            cfg_wlen = 2'(w);
            for (int v = 0; v < 32; v++) begin
                send(8'(v * 7 + 8'hE0), 5 + w, 0, 1, 1, 0);
                rd_expect("R2", 8'(v * 7 + 8'hE0) & 8'((1 << (5 + w)) - 1), 0, 0, 0);
            end
        end

        // R3: parity errors in both modes
        cfg_wlen = 2'd3;
        cfg_par_en = 1'b1;
        cfg_par_even = 1'b0;
        send(8'h3C, 8, 0, 1, 1, 0);
        rd_expect("R3", 8'h3C, 0, 0, 0);
        send(8'h3C, 8, 1, 1, 1, 0);
        rd_expect("R3", 8'h3C, 1, 0, 0);
        cfg_par_even = 1'b1;
        send(8'h01, 8, 1, 1, 1, 0);
        rd_expect("R3", 8'h01, 1, 0, 0);

        // R4: framing errors
        cfg_par_en = 1'b0;
        send(8'h7E, 8, 0, 0, 1, 0);
        rd_expect("R4", 8'h7E, 0, 1, 0);
        cfg_two_stop = 1'b1;
        send(8'h81, 8, 0, 1, 0, 0);
        rd_expect("R4", 8'h81, 0, 1, 0);
        send(8'h81, 8, 0, 1, 1, 0);
        rd_expect("R4", 8'h81, 0, 0, 0);
        cfg_two_stop = 1'b0;

        // R5: break held low yields one character
        cfg_par_en = 1'b1;
        send(8'h00, 8, 0, 0, 0, 64);
        repeat (32) @(negedge clk);
        rd_expect("R5", 8'h00, 0, 1, 1);
        chk("R5", "data_ready after break", data_ready, 0);
        send(8'h44, 8, 0, 1, 1, 0);
        rd_expect("R5", 8'h44, 0, 0, 0);
        cfg_par_en = 1'b0;

        // R6: glitch shorter than half a bit
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (400) @(negedge clk);
        chk("R6", "data_ready after glitch", data_ready, 0);
        send(8'hC3, 8, 0, 1, 1, 0);
        rd_expect("R6", 8'hC3, 0, 0, 0);

        // R7/R8: fill past 64 entries
        for (int i = 0; i < 64; i++) send(8'(i + 8'h10), 8, 0, 1, 1, 0);
        chk("R8", "overrun at 64", overrun, 0);
        send(8'hEE, 8, 0, 1, 1, 0);
        chk("R8", "overrun at 65", overrun, 1);
        for (int i = 0; i < 64; i++) rd_expect("R7", 8'(i + 8'h10), 0, 0, 0);
        chk("R7", "data_ready drained", data_ready, 0);

        // R10: sticky, then cleared
        chk("R10", "overrun sticky", overrun, 1);
        st_rd = 1'b1;
        @(negedge clk);
        st_rd = 1'b0;
        @(negedge clk);
        chk("R10", "overrun cleared", overrun, 0);

        // R7: read strobe on empty queue
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
        chk("R7", "empty read ignored", data_ready, 0);
        send(8'h5A, 8, 0, 1, 1, 0);
        rd_expect("R7", 8'h5A, 0, 0, 0);

        // R9: single slot overwrite
        cfg_fifo_en = 1'b0;
        repeat (2) @(negedge clk);
        send(8'h11, 8, 0, 1, 1, 0);
        chk("R9", "overrun first", overrun, 0);
        send(8'h22, 8, 0, 1, 1, 0);
        chk("R9", "overrun overwrite", overrun, 1);
        rd_expect("R9", 8'h22, 0, 0, 0);
        chk("R9", "single slot empty", data_ready, 0);

        // R11: mode change flushes
        send(8'h33, 8, 0, 1, 1, 0);
        chk("R11", "held before flush", data_ready, 1);
        cfg_fifo_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11", "data_ready flushed", data_ready, 0);
        chk("R11", "overrun flushed", overrun, 0);

        // R12: sparse ticks
        tdiv = 3;
        repeat (4) @(negedge clk);
        send(8'hA5, 8, 0, 1, 1, 0);
        rd_expect("R12", 8'hA5, 0, 0, 0);
        send(8'h96, 8, 0, 1, 1, 0);
        rd_expect("R12", 8'h96, 0, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule